// File: doc/BRIEF.md
# Bus Access Watch and Instruction Breakpoint Monitor

This block sits beside a processor core and watches two things: the data bus (address plus read and write strobes) and the program counter at each instruction boundary. Three small address tables are loaded through a write-only configuration port. One holds read-watch addresses, one holds write-watch addresses and one holds breakpoint PC values. A set of externally evaluated condition lines joins them. When a condition is met, the monitor raises a one-cycle break pulse and reports a cause code, an address and a read/write flag.

A watched access only marks a trap as pending. The break itself is taken at the next instruction boundary, so the core always stops between instructions. Reads tagged as dummy ("ghost") accesses are ignored unless a ghost enable is set. The monitor records the cycle count of every break it reports. At a later boundary that carries the same count, no break is reported, so execution can resume past the point where it stopped. Whenever any conditional check is armed, the monitor asks the core to synchronise its state after every instruction.

Top module: `bus_watch_monitor`

## Requirements
- R1: After reset, `brk_pulse`, `brk_cause`, `brk_addr`, `brk_is_read` and `step_sync` are all zero, and all three tables are empty. Cause codes: 0 none, 1 read watch, 2 write watch, 3 PC breakpoint, 4 conditional.
- R2: A read (`bus_rd`=1) with `rd_kind` 0 (code) or 1 (data) marks a read trap pending when its address equals a valid entry of the read table. Table select 0 picks the read table. A read to an address not in the table, or held only by an invalid entry, marks nothing.
- R3: A read with `rd_kind` 2 (ghost) marks nothing while `ghost_en`=0. With `ghost_en`=1 it is treated like any other read.
- R4: A write (`bus_wr`=1) whose address equals a valid entry of the write table (table select 1) marks a write trap pending, whatever `rd_kind` and `ghost_en` are.
- R5: A pending trap causes no output change by itself. A break is reported as a `brk_pulse` lasting exactly one cycle, in the cycle after the `insn_bound` cycle that takes it. With the pulse come cause 1 with the captured read address and `brk_is_read`=1, or cause 2 with the captured write address and `brk_is_read`=0.
- R6: At a boundary the order of precedence is pending trap, then PC breakpoint (table select 2, PC equal to a valid entry; cause 3), then conditional break (any bit set in `cond_arm & cond_hit`; cause 4). Causes 3 and 4 report `pc` as the address with `brk_is_read`=0. Only the winner is reported.
- R7: When read and write traps are both pending, the break is reported as a read. Reporting any trap clears both pending flags.
- R8: At a boundary whose `cycle` equals the cycle of the last reported break, no break is reported and pending traps are kept.
- R9: The last-break cycle resets to all ones. A first boundary at cycle all ones is therefore suppressed, and one at any other cycle value can break.
- R10: `step_sync` is 1 exactly when at least one bit of `cond_arm` is set. It follows that input combinationally.
- R11: Writing a table entry, including invalidating the entry that caused a trap, leaves pending traps untouched.
- R12: `brk_cause`, `brk_addr` and `brk_is_read` hold their values until the next reported break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| rd_kind | input | 2 | Read tag: 0 code, 1 data, 2 ghost |
| ghost_en | input | 1 | Let ghost reads trigger read traps |
| insn_bound | input | 1 | Instruction-boundary pulse |
| pc | input | ADDR_W | Program counter, valid with `insn_bound` |
| cycle | input | CYC_W | Free-running cycle count |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 read, 1 write, 2 PC |
| cfg_idx | input | IDX_W | Entry index |
| cfg_addr | input | ADDR_W | Entry address |
| cfg_valid | input | 1 | Entry valid bit |
| cond_arm | input | N_COND | Conditional checks armed |
| cond_hit | input | N_COND | Conditional check results |
| brk_pulse | output | 1 | One-cycle break report |
| brk_cause | output | 3 | Cause code of the last break |
| brk_addr | output | ADDR_W | Address of the last break |
| brk_is_read | output | 1 | Last break was a read trap |
| step_sync | output | 1 | Per-instruction sync request |

## Verification
A wrong pending flag shows up at the first instruction boundary after the access. That boundary either brings a break pulse nobody expects or fails to bring one, and the fault is visible at the ports on the next cycle. A corrupted last-break cycle shows up as a break on a repeated cycle count, or as a missing break on a fresh one, again one cycle after the boundary. A priority or address-capture fault shows in `brk_cause`, `brk_addr` and `brk_is_read`, which hold their values until the next break and so stay easy to inspect.

// File: rtl/watch_pkg.sv
package watch_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_RD   = 3'd1,
    CAUSE_WR   = 3'd2,
    CAUSE_PC   = 3'd3,
    CAUSE_COND = 3'd4
  } cause_e;

  localparam logic [1:0] KIND_CODE  = 2'd0;
  localparam logic [1:0] KIND_DATA  = 2'd1;
  localparam logic [1:0] KIND_GHOST = 2'd2;

  localparam logic [1:0] TBL_RD = 2'd0;
  localparam logic [1:0] TBL_WR = 2'd1;
  localparam logic [1:0] TBL_PC = 2'd2;
endpackage

// File: rtl/addr_cam.sv
module addr_cam #(
  parameter int ADDR_W = 16,
  parameter int N_ENT  = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit
);
  logic [N_ENT-1:0] ent_hit;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              vld_q, vld_d;
    logic              sel;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(e));
      addr_d = sel ? wr_addr  : addr_q;
      vld_d  = sel ? wr_valid : vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        vld_q  <= 1'b0;
      end else if (sel) begin
        addr_q <= addr_d;
        vld_q  <= vld_d;
      end
    end

    assign ent_hit[e] = vld_q && (addr_q == look_addr);
  end

  assign hit = |ent_hit;
endmodule

// File: rtl/trap_latch.sv
module trap_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_set,
  input  logic              wr_set,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              trap_clr,
  output logic              rd_pend,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr
);
  logic              rd_pend_d, wr_pend_d;
  logic [ADDR_W-1:0] rd_addr_d, wr_addr_d;
  logic              rd_free, wr_free;

  always_comb begin
    rd_free   = !rd_pend || trap_clr;
    wr_free   = !wr_pend || trap_clr;
    rd_pend_d = (rd_pend && !trap_clr) || rd_set;
    wr_pend_d = (wr_pend && !trap_clr) || wr_set;
    rd_addr_d = (rd_set && rd_free) ? acc_addr : rd_addr;
    wr_addr_d = (wr_set && wr_free) ? acc_addr : wr_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      rd_addr <= '0;
      wr_addr <= '0;
    end else begin
      rd_pend <= rd_pend_d;
      wr_pend <= wr_pend_d;
      rd_addr <= rd_addr_d;
      wr_addr <= wr_addr_d;
    end
  end

  // R2
  rd_set_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_set |=> rd_pend);
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_clr && !rd_set |=> !rd_pend);
  // R7
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_clr && !wr_set |=> !wr_pend);
endmodule

// File: rtl/break_arbiter.sv
module break_arbiter
  import watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_bound,
  input  logic [CYC_W-1:0]  cycle,
  input  logic [ADDR_W-1:0] pc,
  input  logic              rd_pend,
  input  logic              wr_pend,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              pc_hit,
  input  logic              cond_fire,
  output logic              trap_clr,
  output logic              brk_pulse,
  output logic [2:0]        brk_cause,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              brk_is_read
);
  logic [CYC_W-1:0]  last_q, last_d;
  logic              pulse_d, isrd_d, take, allow;
  cause_e            cause_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    allow   = insn_bound && (cycle != last_q);
    cause_d = CAUSE_NONE;
    addr_d  = brk_addr;
    isrd_d  = brk_is_read;
    if (rd_pend) begin
      cause_d = CAUSE_RD;
      addr_d  = rd_addr;
      isrd_d  = 1'b1;
    end else if (wr_pend) begin
      cause_d = CAUSE_WR;
      addr_d  = wr_addr;
      isrd_d  = 1'b0;
    end else if (pc_hit) begin
      cause_d = CAUSE_PC;
      addr_d  = pc;
      isrd_d  = 1'b0;
    end else if (cond_fire) begin
      cause_d = CAUSE_COND;
      addr_d  = pc;
      isrd_d  = 1'b0;
    end
    take     = allow && (cause_d != CAUSE_NONE);
    trap_clr = allow && (rd_pend || wr_pend);
    pulse_d  = take;
    last_d   = take ? cycle : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q      <= '1;
      brk_cause   <= 3'd0;
      brk_addr    <= '0;
      brk_is_read <= 1'b0;
    end else if (take) begin
      last_q      <= last_d;
      brk_cause   <= cause_d;
      brk_addr    <= addr_d;
      brk_is_read <= isrd_d;
    end
  end

  // R5
  pulse_after_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(insn_bound));
  // R8
  same_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_bound && (cycle == last_q) |=> !brk_pulse);
  // R12
  report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_pulse |-> ($stable(brk_cause) && $stable(brk_addr) && $stable(brk_is_read)));
  // R6
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    allow && rd_pend |=> brk_pulse && (brk_cause == 3'd1));
endmodule

// File: rtl/bus_watch_monitor.sv
module bus_watch_monitor
  import watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 32,
  parameter int N_ENT  = 4,
  parameter int N_COND = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        rd_kind,
  input  logic              ghost_en,
  input  logic              insn_bound,
  input  logic [ADDR_W-1:0] pc,
  input  logic [CYC_W-1:0]  cycle,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_valid,
  input  logic [N_COND-1:0] cond_arm,
  input  logic [N_COND-1:0] cond_hit,
  output logic              brk_pulse,
  output logic [2:0]        brk_cause,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              brk_is_read,
  output logic              step_sync
);
  localparam int N_TBL = 3;

  logic [N_TBL-1:0]  tbl_hit;
  logic [ADDR_W-1:0] tbl_look [N_TBL];
  logic              rd_set, wr_set, trap_clr, cond_fire;
  logic              rd_pend, wr_pend;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  assign tbl_look[0] = bus_addr;
  assign tbl_look[1] = bus_addr;
  assign tbl_look[2] = pc;

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    addr_cam #(.ADDR_W(ADDR_W), .N_ENT(N_ENT)) i_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_sel == 2'(t))),
      .wr_idx   (cfg_idx),
      .wr_addr  (cfg_addr),
      .wr_valid (cfg_valid),
      .look_addr(tbl_look[t]),
      .hit      (tbl_hit[t])
    );
  end

  always_comb begin
    rd_set    = bus_rd && tbl_hit[TBL_RD] && ((rd_kind != KIND_GHOST) || ghost_en);
    wr_set    = bus_wr && tbl_hit[TBL_WR];
    cond_fire = |(cond_arm & cond_hit);
    step_sync = |cond_arm;
  end

  trap_latch #(.ADDR_W(ADDR_W)) i_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (rd_set),
    .wr_set  (wr_set),
    .acc_addr(bus_addr),
    .trap_clr(trap_clr),
    .rd_pend (rd_pend),
    .wr_pend (wr_pend),
    .rd_addr (rd_addr),
    .wr_addr (wr_addr)
  );

  break_arbiter #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) i_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_bound (insn_bound),
    .cycle      (cycle),
    .pc         (pc),
    .rd_pend    (rd_pend),
    .wr_pend    (wr_pend),
    .rd_addr    (rd_addr),
    .wr_addr    (wr_addr),
    .pc_hit     (tbl_hit[TBL_PC]),
    .cond_fire  (cond_fire),
    .trap_clr   (trap_clr),
    .brk_pulse  (brk_pulse),
    .brk_cause  (brk_cause),
    .brk_addr   (brk_addr),
    .brk_is_read(brk_is_read)
  );

  // R3
  ghost_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && (rd_kind == KIND_GHOST) && !ghost_en && !rd_pend |=> !rd_pend);
  // R11
  cfg_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && rd_pend && !insn_bound |=> rd_pend);
endmodule

// File: tb/test_bus_watch_monitor.sv
module test_bus_watch_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CYC_W  = 32;
  localparam int N_ENT  = 4;
  localparam int N_COND = 4;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rd, bus_wr;
  logic [1:0]        rd_kind;
  logic              ghost_en, insn_bound;
  logic [ADDR_W-1:0] pc;
  logic [CYC_W-1:0]  cycle;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [IDX_W-1:0]  cfg_idx;
  logic [ADDR_W-1:0] cfg_addr;
  logic              cfg_valid;
  logic [N_COND-1:0] cond_arm, cond_hit;
  logic              brk_pulse, brk_is_read, step_sync;
  logic [2:0]        brk_cause;
  logic [ADDR_W-1:0] brk_addr;

  int checks = 0;
  int errors = 0;
  logic [CYC_W-1:0] cnow = 32'd100;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_watch_monitor #(.ADDR_W(ADDR_W), .CYC_W(CYC_W), .N_ENT(N_ENT), .N_COND(N_COND))
  i_bus_watch_monitor (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rd_kind(rd_kind), .ghost_en(ghost_en), .insn_bound(insn_bound), .pc(pc),
    .cycle(cycle), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .cond_arm(cond_arm), .cond_hit(cond_hit),
    .brk_pulse(brk_pulse), .brk_cause(brk_cause), .brk_addr(brk_addr),
    .brk_is_read(brk_is_read), .step_sync(step_sync)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, int idx, logic [15:0] a, logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IDX_W'(idx); cfg_addr = a; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_acc(logic [15:0] a, logic [1:0] kind);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; rd_kind = kind;
    @(negedge clk);
    bus_rd = 1'b0; rd_kind = 2'd0;
  endtask

  task automatic wr_acc(logic [15:0] a, logic [1:0] kind);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; rd_kind = kind;
    @(negedge clk);
    bus_wr = 1'b0; rd_kind = 2'd0;
  endtask

  // Boundary at given pc and cycle; returns at the negedge where the report is visible.
  task automatic boundary(logic [15:0] p, logic [31:0] c);
    @(negedge clk);
    insn_bound = 1'b1; pc = p; cycle = c;
    @(negedge clk);
    insn_bound = 1'b0;
  endtask

  task automatic expect_brk(string req, logic [2:0] cause, logic [15:0] a, logic isrd);
    check(req, "pulse", 32'(brk_pulse), 32'd1);
    check(req, "cause", 32'(brk_cause), 32'(cause));
    check(req, "addr", 32'(brk_addr), 32'(a));
    check(req, "is_read", 32'(brk_is_read), 32'(isrd));
  endtask

  function automatic logic [31:0] nc();
    cnow = cnow + 32'd1;
    return cnow;
  endfunction

  task automatic t_reset();
    check("R1", "pulse", 32'(brk_pulse), 32'd0);
    check("R1", "cause", 32'(brk_cause), 32'd0);
    check("R1", "addr", 32'(brk_addr), 32'd0);
    check("R1", "is_read", 32'(brk_is_read), 32'd0);
    check("R1", "step_sync", 32'(step_sync), 32'd0);
    boundary(16'h1234, nc());
    check("R1", "empty pc table", 32'(brk_pulse), 32'd0);
  endtask

  task automatic t_first_cycle();
    cfg(2'd2, 0, 16'h1234, 1'b1);
    boundary(16'h1234, 32'hFFFF_FFFF);
    check("R9", "all-ones cycle suppressed", 32'(brk_pulse), 32'd0);
    boundary(16'h1234, 32'd0);
    expect_brk("R9", 3'd3, 16'h1234, 1'b0);
  endtask

  task automatic t_read_trap();
    cfg(2'd0, 1, 16'h0080, 1'b1);
    rd_acc(16'h0081, 2'd1);
    boundary(16'h2000, nc());
    check("R2", "miss no break", 32'(brk_pulse), 32'd0);
    rd_acc(16'h0080, 2'd0);
    check("R5", "pending alone no pulse", 32'(brk_pulse), 32'd0);
    boundary(16'h2000, nc());
    expect_brk("R2", 3'd1, 16'h0080, 1'b1);
    @(negedge clk);
    check("R5", "pulse one cycle", 32'(brk_pulse), 32'd0);
  endtask

  task automatic t_ghost();
    ghost_en = 1'b0;
    rd_acc(16'h0080, 2'd2);
    boundary(16'h2000, nc());
    check("R3", "ghost ignored", 32'(brk_pulse), 32'd0);
    ghost_en = 1'b1;
    rd_acc(16'h0080, 2'd2);
    boundary(16'h2000, nc());
    expect_brk("R3", 3'd1, 16'h0080, 1'b1);
    ghost_en = 1'b0;
  endtask

  task automatic t_write();
    cfg(2'd1, 2, 16'h0300, 1'b1);
    wr_acc(16'h0300, 2'd2);
    boundary(16'h2000, nc());
    expect_brk("R4", 3'd2, 16'h0300, 1'b0);
  endtask

  task automatic t_both();
    rd_acc(16'h0080, 2'd1);
    wr_acc(16'h0300, 2'd1);
    boundary(16'h1234, nc());
    expect_brk("R7", 3'd1, 16'h0080, 1'b1);
    boundary(16'h2000, nc());
    check("R7", "both cleared", 32'(brk_pulse), 32'd0);
  endtask

  task automatic t_prio();
    cond_arm = 4'b0010; cond_hit = 4'b0010;
    boundary(16'h1234, nc());
    expect_brk("R6", 3'd3, 16'h1234, 1'b0);
    boundary(16'h2000, nc());
    expect_brk("R6", 3'd4, 16'h2000, 1'b0);
    cond_hit = 4'b0001;
    boundary(16'h2000, nc());
    check("R6", "unarmed hit ignored", 32'(brk_pulse), 32'd0);
    cond_arm = '0; cond_hit = '0;
  endtask

  task automatic t_suppress();
    logic [31:0] c;
    c = nc();
    boundary(16'h1234, c);
    expect_brk("R8", 3'd3, 16'h1234, 1'b0);
    boundary(16'h1234, c);
    check("R8", "same cycle pc", 32'(brk_pulse), 32'd0);
    rd_acc(16'h0080, 2'd0);
    boundary(16'h2000, c);
    check("R8", "same cycle trap", 32'(brk_pulse), 32'd0);
    boundary(16'h2000, nc());
    expect_brk("R8", 3'd1, 16'h0080, 1'b1);
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    boundary(16'h2000, nc());
    check("R12", "pulse", 32'(brk_pulse), 32'd0);
    check("R12", "cause held", 32'(brk_cause), 32'd1);
    check("R12", "addr held", 32'(brk_addr), 32'h0080);
    check("R12", "is_read held", 32'(brk_is_read), 32'd1);
  endtask

  task automatic t_prog();
    rd_acc(16'h0080, 2'd1);
    cfg(2'd0, 1, 16'h0080, 1'b0);
    boundary(16'h2000, nc());
    expect_brk("R11", 3'd1, 16'h0080, 1'b1);
    rd_acc(16'h0080, 2'd1);
    boundary(16'h2000, nc());
    check("R2", "invalid entry no match", 32'(brk_pulse), 32'd0);
  endtask

  task automatic t_sync();
    @(negedge clk);
    cond_arm = 4'b1000;
    #1;
    check("R10", "armed", 32'(step_sync), 32'd1);
    cond_arm = '0;
    #1;
    check("R10", "disarmed", 32'(step_sync), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; rd_kind = 2'd0;
    ghost_en = 1'b0; insn_bound = 1'b0; pc = '0; cycle = '0; cfg_we = 1'b0;
    cfg_sel = 2'd0; cfg_idx = '0; cfg_addr = '0; cfg_valid = 1'b0;
    cond_arm = '0; cond_hit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_cycle();
    t_read_trap();
    t_ghost();
    t_write();
    t_both();
    t_prio();
    t_suppress();
    t_hold();
    t_prog();
    t_sync();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule